// File: doc/BRIEF.md
# Per-Block Write-Protect Lock Manager

This block holds a protection state for each erase block of a flash array and applies lock commands to a range of blocks. A block is in exactly one of three states: open (programmable), locked, or lock-tight. Lock-tight is sticky: it can only be left through reset. The range is set through two index registers, a start and an end. A command is given as an 8-bit opcode with a one-cycle strobe.

A command walks its range one block per clock. While it walks, `busy` is high. When the walk ends, `done` pulses for one cycle, together with `range_err` if the walk ran past the last block that exists. A status output holds the state most recently written into any block.

The program and erase paths read the state of any block through a combinational query port. They refuse to act on blocks that are not open.

Top module: `wp_lock_mgr`

## Requirements
- R1: After synchronous active-low reset every block reads locked (3'b010) on the query port, `wp_status` is 16'h0002, `busy`, `done` and `range_err` are 0, and both range indices are 0.
- R2: A start-register write (`rng_wr_start`) loads `rng_wdata` into both the start and the end index. An end-register write (`rng_wr_end`, without a start write in the same cycle) changes only the end index. Both take effect on the next clock.
- R3: Opcode 8'h23 sets blocks from start to end inclusive to open (3'b100), in ascending order. The walk ends, with no change, at the first block found lock-tight (3'b001).
- R4: Opcode 8'h2A sets blocks from start to end inclusive to locked (3'b010). The walk ends, with no change, at the first lock-tight block.
- R5: Opcode 8'h27 opens blocks from block 0 up to the last block. The walk ends at the first lock-tight block.
- R6: Opcode 8'h2C sets every block in start..end that is not open to lock-tight. Open blocks are left as they are, and the walk continues past them.
- R7: If a walk reaches an index at or above NUM_BLOCKS, it ends there. `range_err` is high in the cycle `done` is high. Blocks already visited keep their new state.
- R8: `wp_status` is {13'b0, state} of the last block written by a walk. An open block skipped by 8'h2C does not update it.
- R9: The walk starts on the clock edge that accepts the command. It then visits one block per clock, with `busy` high in the cycle before each visit. `done` is high for the one cycle after the final visit, and `busy` is low then. A range command with start > end gives `done` on the cycle after acceptance, with `busy` never high.
- R10: A strobe while `busy` is high, and any opcode other than 8'h23, 8'h2A, 8'h27 and 8'h2C, changes nothing and produces no `done`.
- R11: `qry_state` shows the state of block `qry_idx` in the same cycle. For an index at or above NUM_BLOCKS it reads 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rng_wr_start | input | 1 | Write strobe for the start index (also loads the end index) |
| rng_wr_end | input | 1 | Write strobe for the end index |
| rng_wdata | input | BLK_W | Index value for the range writes |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| qry_idx | input | BLK_W | Block index for the query port |
| qry_state | output | 3 | One-hot state of the queried block |
| rng_start | output | BLK_W | Current start index |
| rng_end | output | BLK_W | Current end index |
| wp_status | output | 16 | Last state written by a walk |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse when a walk or an empty command ends |
| range_err | output | 1 | A walk ran past the last block (valid with done) |

## Verification
The range error is the hardest state to reach from the ports. The index registers are as wide as the index, so the error only shows up because the default block count (12) is not a power of two. The stimulus sets an end index of 14 and watches the walk open blocks 9 to 11 before it fails at 12. The lock-tight stops need history: a tighten walk must first leave sticky blocks in place, and the later unlock and lock walks then end on those blocks. Dropping a command while busy is tested by a second strobe issued in the middle of a five-block walk.

// File: rtl/wp_lock_pkg.sv
// Package: shared state codes, opcodes and walk kinds for the lock manager.
// Assumes the one-hot 3-bit state code is decoded elsewhere (program/erase gating).
package wp_lock_pkg;
    localparam logic [2:0] LK_TIGHT  = 3'b001;
    localparam logic [2:0] LK_LOCKED = 3'b010;
    localparam logic [2:0] LK_OPEN   = 3'b100;

    localparam logic [7:0] OP_OPEN_RANGE  = 8'h23;
    localparam logic [7:0] OP_OPEN_ALL    = 8'h27;
    localparam logic [7:0] OP_LOCK_RANGE  = 8'h2A;
    localparam logic [7:0] OP_TIGHT_RANGE = 8'h2C;

    typedef enum logic [1:0] {
        WK_OPEN  = 2'd0,
        WK_LOCK  = 2'd1,
        WK_TIGHT = 2'd2
    } walk_kind_t;
endpackage

// File: rtl/wp_range_regs.sv
// Range index registers. A start write loads both indices; an end write loads
// only the end. Assumes the two strobes come from a decoded host write.
module wp_range_regs #(
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start,
    input  logic             wr_end,
    input  logic [BLK_W-1:0] wdata,
    output logic [BLK_W-1:0] start_q,
    output logic [BLK_W-1:0] end_q
);
    // Load the range indices from host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
        end else if (wr_start) begin
            start_q <= wdata;
            end_q   <= wdata;
        end else if (wr_end) begin
            end_q <= wdata;
        end
    end
endmodule

// File: rtl/wp_lock_store.sv
// Per-block state store: one 3-bit register per block, one write port and two
// combinational read ports. Indices at or above NUM_BLOCKS read as zero.
module wp_lock_store
    import wp_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int BLK_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_idx,
    input  logic [2:0]       wr_state,
    input  logic [BLK_W-1:0] qa_idx,
    output logic [2:0]       qa_state,
    input  logic [BLK_W-1:0] qb_idx,
    output logic [2:0]       qb_state
);
    logic [2:0] st [NUM_BLOCKS];

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
        // Hold one block's state; reset puts every block in the locked state.
        always_ff @(posedge clk) begin
            if (!rst_n)
                st[g] <= LK_LOCKED;
            else if (wr_en && (wr_idx == BLK_W'(g)))
                st[g] <= wr_state;
        end
    end

    // Query port read mux.
    always_comb begin
        qa_state = 3'b000;
        for (int i = 0; i < NUM_BLOCKS; i++)
            if (qa_idx == BLK_W'(i)) qa_state = st[i];
    end

    // Walk read mux.
    always_comb begin
        qb_state = 3'b000;
        for (int i = 0; i < NUM_BLOCKS; i++)
            if (qb_idx == BLK_W'(i)) qb_state = st[i];
    end
endmodule

// File: rtl/wp_sweep_ctrl.sv
// Walk controller: accepts a lock command when idle and visits one block per
// clock. It stops at a lock-tight block (open/lock walks), at the end index,
// or at an index that does not exist (range error).
// Assumes cur_state is the combinational state of block cur_idx.
module wp_sweep_ctrl
    import wp_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int BLK_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_op,
    input  logic [BLK_W-1:0] rng_start,
    input  logic [BLK_W-1:0] rng_end,
    output logic [BLK_W-1:0] cur_idx,
    input  logic [2:0]       cur_state,
    output logic             st_wr_en,
    output logic [2:0]       st_wr_state,
    output logic [2:0]       last_written,
    output logic             busy,
    output logic             done,
    output logic             range_err
);
    localparam logic [BLK_W:0]   NB_EXT   = (BLK_W+1)'(NUM_BLOCKS);
    localparam logic [BLK_W-1:0] LAST_IDX = BLK_W'(NUM_BLOCKS - 1);

    logic             busy_q, done_q, err_q;
    walk_kind_t       kind_q;
    logic [BLK_W-1:0] cur_q, last_q;
    logic [2:0]       status_q;

    logic             dec_known, dec_ranged;
    walk_kind_t       dec_kind;
    logic [BLK_W-1:0] dec_first, dec_last;
    logic             accept, empty;
    logic             cur_exists, is_tight, is_open, blocked, finish;
    logic [2:0]       new_state;

    // Decode the opcode into a walk kind and its index bounds.
    always_comb begin
        dec_known  = 1'b1;
        dec_ranged = 1'b1;
        dec_kind   = WK_OPEN;
        dec_first  = rng_start;
        dec_last   = rng_end;
        case (cmd_op)
            OP_OPEN_RANGE:  dec_kind = WK_OPEN;
            OP_LOCK_RANGE:  dec_kind = WK_LOCK;
            OP_TIGHT_RANGE: dec_kind = WK_TIGHT;
            OP_OPEN_ALL: begin
                dec_ranged = 1'b0;
                dec_first  = '0;
                dec_last   = LAST_IDX;
            end
            default: dec_known = 1'b0;
        endcase
    end

    assign accept = cmd_valid && !busy_q && dec_known;
    assign empty  = dec_ranged && (rng_start > rng_end);

    // Judge the block under the walk pointer.
    always_comb begin
        cur_exists = {1'b0, cur_q} < NB_EXT;
        is_tight   = (cur_state == LK_TIGHT);
        is_open    = (cur_state == LK_OPEN);
        case (kind_q)
            WK_TIGHT: new_state = LK_TIGHT;
            WK_LOCK:  new_state = LK_LOCKED;
            default:  new_state = LK_OPEN;
        endcase
        blocked  = (kind_q != WK_TIGHT) && is_tight;
        st_wr_en = busy_q && cur_exists &&
                   ((kind_q == WK_TIGHT) ? !is_open : !is_tight);
        finish   = !cur_exists || blocked || (cur_q == last_q);
    end

    // Walk sequencing, done and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            kind_q <= WK_OPEN;
            cur_q  <= '0;
            last_q <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (busy_q) begin
                if (finish) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    err_q  <= !cur_exists;
                end else begin
                    cur_q <= cur_q + 1'b1;
                end
            end else if (accept) begin
                if (empty) begin
                    done_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                    kind_q <= dec_kind;
                    cur_q  <= dec_first;
                    last_q <= dec_last;
                end
            end
        end
    end

    // Remember the most recently written state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= LK_LOCKED;
        else if (st_wr_en)
            status_q <= new_state;
    end

    assign cur_idx      = cur_q;
    assign st_wr_state  = new_state;
    assign last_written = status_q;
    assign busy         = busy_q;
    assign done         = done_q;
    assign range_err    = err_q;
endmodule

// File: rtl/wp_lock_mgr.sv
// Top: per-block write-protect lock manager. Combines the range registers,
// the state store and the walk controller. Reset is synchronous, active low.
module wp_lock_mgr #(
    parameter int NUM_BLOCKS = 12,
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rng_wr_start,
    input  logic             rng_wr_end,
    input  logic [BLK_W-1:0] rng_wdata,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_op,
    input  logic [BLK_W-1:0] qry_idx,
    output logic [2:0]       qry_state,
    output logic [BLK_W-1:0] rng_start,
    output logic [BLK_W-1:0] rng_end,
    output logic [15:0]      wp_status,
    output logic             busy,
    output logic             done,
    output logic             range_err
);
    logic [BLK_W-1:0] cur_idx;
    logic [2:0]       cur_state, wr_state, last_written;
    logic             wr_en;

    wp_range_regs #(.BLK_W(BLK_W)) u_range (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_start (rng_wr_start),
        .wr_end   (rng_wr_end),
        .wdata    (rng_wdata),
        .start_q  (rng_start),
        .end_q    (rng_end)
    );

    wp_lock_store #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (cur_idx),
        .wr_state (wr_state),
        .qa_idx   (qry_idx),
        .qa_state (qry_state),
        .qb_idx   (cur_idx),
        .qb_state (cur_state)
    );

    wp_sweep_ctrl #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_sweep (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .rng_start    (rng_start),
        .rng_end      (rng_end),
        .cur_idx      (cur_idx),
        .cur_state    (cur_state),
        .st_wr_en     (wr_en),
        .st_wr_state  (wr_state),
        .last_written (last_written),
        .busy         (busy),
        .done         (done),
        .range_err    (range_err)
    );

    assign wp_status = {13'b0, last_written};
endmodule

// File: rtl/wp_lock_mgr_chk.sv
// Checker for the lock manager's port-level behaviour, bound to the top.
module wp_lock_mgr_chk #(
    parameter int NUM_BLOCKS = 12,
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rng_wr_start,
    input logic             rng_wr_end,
    input logic [BLK_W-1:0] rng_wdata,
    input logic [BLK_W-1:0] qry_idx,
    input logic [2:0]       qry_state,
    input logic [BLK_W-1:0] rng_start,
    input logic [BLK_W-1:0] rng_end,
    input logic [15:0]      wp_status,
    input logic             busy,
    input logic             done,
    input logic             range_err
);
    localparam logic [BLK_W:0] NB_EXT = (BLK_W+1)'(NUM_BLOCKS);

    a_r2_start_loads_both: assert property (@(posedge clk) disable iff (!rst_n)
        rng_wr_start |=> (rng_start == $past(rng_wdata)) && (rng_end == $past(rng_wdata)));

    a_r2_end_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rng_wr_end && !rng_wr_start) |=> (rng_end == $past(rng_wdata)) && $stable(rng_start));

    a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> done);

    a_r8_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(wp_status) == 1) && (wp_status[15:3] == 13'b0));

    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r9_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r11_query_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, qry_idx} < NB_EXT) |-> ($countones(qry_state) == 1));

    a_r11_query_absent: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, qry_idx} >= NB_EXT) |-> (qry_state == 3'b000));
endmodule

bind wp_lock_mgr wp_lock_mgr_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rng_wr_start (rng_wr_start),
    .rng_wr_end   (rng_wr_end),
    .rng_wdata    (rng_wdata),
    .qry_idx      (qry_idx),
    .qry_state    (qry_state),
    .rng_start    (rng_start),
    .rng_end      (rng_end),
    .wp_status    (wp_status),
    .busy         (busy),
    .done         (done),
    .range_err    (range_err)
);

// File: tb/wp_lock_mgr_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated on every rising edge and compared
// with all outputs on every falling edge, plus directed checks per requirement.
module wp_lock_mgr_tb_top;
    localparam int NB = 12;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rng_wr_start = 1'b0, rng_wr_end = 1'b0;
    logic [BW-1:0] rng_wdata = '0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_op = 8'h00;
    logic [BW-1:0] qry_idx = '0;
    logic [2:0]    qry_state;
    logic [BW-1:0] rng_start, rng_end;
    logic [15:0]   wp_status;
    logic          busy, done, range_err;

    int checks = 0;
    int failures = 0;
    bit mon_on = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    wp_lock_mgr #(.NUM_BLOCKS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rng_wr_start(rng_wr_start), .rng_wr_end(rng_wr_end), .rng_wdata(rng_wdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .qry_idx(qry_idx), .qry_state(qry_state),
        .rng_start(rng_start), .rng_end(rng_end),
        .wp_status(wp_status), .busy(busy), .done(done), .range_err(range_err)
    );

    // Reference model state
    int m_st [NB];
    int m_busy, m_done, m_err, m_status, m_start, m_end, m_cur, m_last, m_kind;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update at each rising edge.
    always @(posedge clk) begin
        int s, ns;
        bit fin, known, ranged;
        m_done = 0;
        m_err  = 0;
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) m_st[i] = 2;
            m_busy = 0; m_status = 2; m_start = 0; m_end = 0;
            m_cur = 0; m_last = 0; m_kind = 0;
        end else begin
            if (m_busy != 0) begin
                if (m_cur >= NB) begin
                    m_err = 1; m_done = 1; m_busy = 0;
                end else begin
                    s   = m_st[m_cur];
                    fin = (m_cur == m_last);
                    if (m_kind == 2) begin
                        if (s != 4) begin m_st[m_cur] = 1; m_status = 1; end
                    end else if (s == 1) begin
                        fin = 1;
                    end else begin
                        ns = (m_kind == 1) ? 2 : 4;
                        m_st[m_cur] = ns; m_status = ns;
                    end
                    if (fin) begin m_busy = 0; m_done = 1; end
                    else m_cur++;
                end
            end else if (cmd_valid) begin
                known = 1; ranged = 1;
                case (cmd_op)
                    8'h23: m_kind = 0;
                    8'h2A: m_kind = 1;
                    8'h2C: m_kind = 2;
                    8'h27: begin m_kind = 0; ranged = 0; end
                    default: known = 0;
                endcase
                if (known) begin
                    if (ranged && m_start > m_end) m_done = 1;
                    else begin
                        m_busy = 1;
                        m_cur  = ranged ? m_start : 0;
                        m_last = ranged ? m_end : NB - 1;
                    end
                end
            end
            if (rng_wr_start) begin m_start = rng_wdata; m_end = rng_wdata; end
            else if (rng_wr_end) m_end = rng_wdata;
        end
    end

    // Compare every output with the model at each falling edge.
    always @(negedge clk) begin
        int qe;
        if (mon_on && !finished) begin
            chk(busy == m_busy[0], "R9 busy", busy, m_busy);
            chk(done == m_done[0], "R9 done", done, m_done);
            chk(range_err == m_err[0], "R7 range_err", range_err, m_err);
            chk(wp_status == 16'(m_status), "R8 wp_status", wp_status, m_status);
            chk(rng_start == BW'(m_start), "R2 rng_start", rng_start, m_start);
            chk(rng_end == BW'(m_end), "R2 rng_end", rng_end, m_end);
            qe = (int'(qry_idx) < NB) ? m_st[qry_idx] : 0;
            chk(qry_state == 3'(qe), "R11 qry_state", qry_state, qe);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr_start(input int v);
        rng_wr_start = 1'b1; rng_wdata = BW'(v); step(); rng_wr_start = 1'b0;
    endtask

    task automatic wr_end(input int v);
        rng_wr_end = 1'b1; rng_wdata = BW'(v); step(); rng_wr_end = 1'b0;
    endtask

    task automatic do_cmd(input logic [7:0] op);
        cmd_valid = 1'b1; cmd_op = op; step(); cmd_valid = 1'b0;
    endtask

    // Wait for done, counting cycles with busy high; returns err seen with done.
    task automatic wait_done(output int bc, output int err);
        int lim = 0;
        bc = 0;
        while (!done && lim < 100) begin
            if (busy) bc++;
            step();
            lim++;
        end
        err = range_err;
    endtask

    task automatic probe(input int k, input int exp, input string tag);
        qry_idx = BW'(k); #1;
        chk(qry_state == 3'(exp), tag, qry_state, exp);
    endtask

    initial begin
        int bc, er;
        repeat (3) step();
        rst_n = 1'b1;
        mon_on = 1;
        step();

        // R1 reset state
        chk(busy == 0 && done == 0 && range_err == 0, "R1 flags", {busy, done, range_err}, 0);
        chk(wp_status == 16'h0002, "R1 wp_status", wp_status, 2);
        chk(rng_start == 0 && rng_end == 0, "R1 range", rng_end, 0);
        probe(0, 2, "R1 block0");
        probe(11, 2, "R1 block11");

        // R2 range registers
        wr_start(3);
        chk(rng_start == 3 && rng_end == 3, "R2 start loads both", rng_end, 3);
        wr_end(5);
        chk(rng_start == 3 && rng_end == 5, "R2 end only", {rng_start, rng_end}, 8'h35);

        // R3 open 3..5
        do_cmd(8'h23); wait_done(bc, er);
        chk(bc == 3, "R9 busy cycles open 3..5", bc, 3);
        probe(4, 4, "R3 block4 open");
        probe(2, 2, "R3 block2 untouched");
        probe(6, 2, "R3 block6 untouched");
        chk(wp_status == 16'h0004, "R8 status open", wp_status, 4);

        // R6 tighten 2..6, open blocks skipped
        wr_start(2); wr_end(6);
        do_cmd(8'h2C); wait_done(bc, er);
        chk(bc == 5, "R6 busy cycles", bc, 5);
        probe(2, 1, "R6 block2 tight");
        probe(4, 4, "R6 block4 skipped");
        probe(6, 1, "R6 block6 tight");
        chk(wp_status == 16'h0001, "R8 status tight", wp_status, 1);

        // R3 open 0..11 stops at tight block 2
        wr_start(0); wr_end(11);
        do_cmd(8'h23); wait_done(bc, er);
        chk(bc == 3, "R3 stop at tight", bc, 3);
        probe(1, 4, "R3 block1 open");
        probe(7, 2, "R3 block7 not reached");

        // R4 lock
        wr_start(0); wr_end(1);
        do_cmd(8'h2A); wait_done(bc, er);
        probe(0, 2, "R4 block0 locked");
        chk(wp_status == 16'h0002, "R8 status lock", wp_status, 2);
        wr_start(1); wr_end(4);
        do_cmd(8'h2A); wait_done(bc, er);
        chk(bc == 2, "R4 stop at tight", bc, 2);
        probe(3, 4, "R4 block3 unchanged");

        // R5 open all stops at block 2
        do_cmd(8'h27); wait_done(bc, er);
        chk(bc == 3, "R5 busy cycles", bc, 3);
        probe(0, 4, "R5 block0 open");
        probe(1, 4, "R5 block1 open");

        // R7 walk past the last block
        wr_start(9); wr_end(14);
        do_cmd(8'h23); wait_done(bc, er);
        chk(bc == 4, "R7 busy cycles", bc, 4);
        chk(er == 1, "R7 range_err with done", er, 1);
        probe(11, 4, "R7 block11 open");

        // R9 empty range
        wr_start(5); wr_end(3);
        do_cmd(8'h2A); wait_done(bc, er);
        chk(bc == 0 && done == 1, "R9 empty range", bc, 0);
        probe(5, 4, "R9 block5 unchanged");

        // R10 strobe while busy is ignored
        wr_start(7); wr_end(11);
        do_cmd(8'h2A);
        step();
        do_cmd(8'h2C);
        wait_done(bc, er);
        repeat (8) step();
        probe(8, 2, "R10 busy strobe ignored");

        // R10 unknown opcode
        do_cmd(8'h55);
        for (int i = 0; i < 4; i++) begin
            chk(done == 0 && busy == 0, "R10 unknown opcode", {busy, done}, 0);
            step();
        end

        // R11 absent blocks
        probe(12, 0, "R11 index 12");
        probe(15, 0, "R11 index 15");
        step();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL R9 watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule